// File: doc/BRIEF.md
# Time Stamp and Gate Generator

A shared timing block that gives several counter channels a common sense of time. A prescaler divides the system clock down to a one-microsecond base tick. A decade divider then selects how many base ticks advance a free-running 16-bit time stamp: 1, 10, 100 or 1000 µs per count. A second divider, built on the same base tick, produces a square gate whose high and low phases each last a programmable number of milliseconds. The channels use this gate to bound frequency-measurement windows. One-cycle strobes mark the start and the end of each high phase.

Configuration goes through a small register port with a write strobe, a one-bit address and a 16-bit data word. A combinational read path returns the active settings. The time stamp and the gate are plain level outputs that every channel samples, so they have no handshake and no back-pressure. The block never stalls, and nothing downstream can hold it.

Top module: `tsgate_top`

## Requirements
- R1: A base tick occurs once every CLK_HZ/1,000,000 clock cycles, and its phase restarts at reset.
- R2: Register address 0, bits [1:0], selects the time stamp resolution: code 0 = 1 µs, 1 = 10 µs, 2 = 100 µs, 3 = 1000 µs. With a steady setting, the time stamp rises by exactly one every resolution period.
- R3: The time stamp is 16 bits wide and counts without stopping. It goes from 0xFFFF to 0x0000 and starts at 0 after reset.
- R4: A new resolution takes effect at the first base tick after the write. The decade phase restarts there, so the first increment comes one full new period after that tick.
- R5: The gate is low after reset. It then alternates between low and high, and each phase lasts the divisor in milliseconds. The divisor is written at address 1, bits [13:0] of the data word. One millisecond is US_PER_MS base ticks.
- R6: gate_start_o is a one-cycle pulse in the first cycle the gate is high. gate_end_o is a one-cycle pulse in the first cycle the gate is low again.
- R7: A divisor write of 0 stores 1. A write above 16382 stores 16382.
- R8: Reading address 0 returns the resolution code in bits [1:0] with zeros above. Reading address 1 returns the stored divisor. After reset the two values are 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 resolution, 1 gate divisor |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| stamp_o | output | 16 | Shared time stamp |
| gate_o | output | 1 | Gate level |
| gate_start_o | output | 1 | Strobe on the first high cycle of the gate |
| gate_end_o | output | 1 | Strobe on the first low cycle after a high phase |

## Verification
A register write becomes visible on cfg_rdata one edge later. Once a resolution is steady, stamp changes are exactly period × cycles-per-µs edges apart. After a resolution write, the first change falls between L·C+1 and (L+1)·C edges later, where L is the new period in µs and C is the cycles per µs. Each gate phase lasts divisor × US_PER_MS × C edges, and a new divisor is measured only after one gate edge has passed. The bench counts edges from negative-edge samples, so every interval it measures is the exact edge difference, and each check compares against the value due at that point.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int unsigned DIV_W   = 14;
  localparam int unsigned DIV_MAX = 16382;
  localparam int unsigned DEC_W   = 10;

  typedef enum logic [1:0] {
    RES_1US    = 2'd0,
    RES_10US   = 2'd1,
    RES_100US  = 2'd2,
    RES_1000US = 2'd3
  } res_e;

  function automatic logic [DEC_W-1:0] res_limit(input res_e r);
    case (r)
      RES_1US:   res_limit = DEC_W'(1);
      RES_10US:  res_limit = DEC_W'(10);
      RES_100US: res_limit = DEC_W'(100);
      default:   res_limit = DEC_W'(1000);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] clamp_div(input logic [15:0] v);
    if (v == 16'd0)                 clamp_div = DIV_W'(1);
    else if (v > 16'(DIV_MAX))      clamp_div = DIV_W'(DIV_MAX);
    else                            clamp_div = v[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/tsg_us_prescaler.sv
module tsg_us_prescaler #(
  parameter int unsigned CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick_o
);
  generate
    if (CYC_PER_US <= 1) begin : g_pass
      assign us_tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CYC_PER_US);
      logic [CW-1:0] cnt_q;
      logic          tick_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= (cnt_q == CW'(CYC_PER_US - 1));
          cnt_q  <= (cnt_q == CW'(CYC_PER_US - 1)) ? '0 : cnt_q + 1'b1;
        end
      end
      assign us_tick_o = tick_q;

      assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/tsg_regs.sv
module tsg_regs
  import tsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output res_e             res_o,
  output logic             res_wr_o,
  output logic [DIV_W-1:0] div_o
);
  res_e             res_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= RES_1US;
      div_q <= DIV_W'(1);
    end else if (we_i) begin
      if (!addr_i) res_q <= res_e'(wdata_i[1:0]);
      else         div_q <= clamp_div(wdata_i);
    end
  end

  assign res_wr_o = we_i && !addr_i;
  assign res_o    = res_q;
  assign div_o    = div_q;
  assign rdata_o  = addr_i ? 16'(div_q) : {14'd0, res_q};

  assert_div_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(1)) && (div_q <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/tsg_stamp.sv
module tsg_stamp
  import tsg_pkg::*;
#(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick_i,
  input  res_e            res_i,
  input  logic            res_wr_i,
  output logic [TS_W-1:0] ts_o
);
  res_e             res_act_q;
  logic             pend_q;
  logic [DEC_W-1:0] dcnt_q;
  logic [TS_W-1:0]  ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_act_q <= RES_1US;
      pend_q    <= 1'b0;
      dcnt_q    <= '0;
      ts_q      <= '0;
    end else begin
      if (us_tick_i) begin
        if (pend_q) begin
          res_act_q <= res_i;
          dcnt_q    <= '0;
        end else if (dcnt_q >= res_limit(res_act_q) - 1'b1) begin
          dcnt_q <= '0;
          ts_q   <= ts_q + 1'b1;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
      if (res_wr_i)       pend_q <= 1'b1;
      else if (us_tick_i) pend_q <= 1'b0;
    end
  end

  assign ts_o = ts_q;

  assert_ts_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts_q) |-> (ts_q == $past(ts_q) + 1'b1));
  assert_ts_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts_q) |-> $past(us_tick_i));
  assert_res_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(us_tick_i)) |-> $stable(res_act_q));
endmodule

// File: rtl/tsg_gate.sv
module tsg_gate
  import tsg_pkg::*;
#(
  parameter int unsigned US_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             gate_o,
  output logic             start_o,
  output logic             end_o
);
  logic ms_tick;

  generate
    if (US_PER_MS <= 1) begin : g_ms_pass
      assign ms_tick = us_tick_i;
    end else begin : g_ms_div
      localparam int unsigned MW = $clog2(US_PER_MS);
      logic [MW-1:0] mcnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) mcnt_q <= '0;
        else if (us_tick_i)
          mcnt_q <= (mcnt_q == MW'(US_PER_MS - 1)) ? '0 : mcnt_q + 1'b1;
      end
      assign ms_tick = us_tick_i && (mcnt_q == MW'(US_PER_MS - 1));
    end
  endgenerate

  logic [DIV_W-1:0] gcnt_q;
  logic             gate_q, start_q, end_q;
  logic             hit;

  assign hit = ms_tick && (gcnt_q >= div_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt_q  <= '0;
      gate_q  <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      start_q <= hit && !gate_q;
      end_q   <= hit && gate_q;
      if (hit) begin
        gcnt_q <= '0;
        gate_q <= !gate_q;
      end else if (ms_tick) begin
        gcnt_q <= gcnt_q + 1'b1;
      end
    end
  end

  assign gate_o  = gate_q;
  assign start_o = start_q;
  assign end_o   = end_q;

  assert_start_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> start_q);
  assert_end_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> end_q);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && end_q));
  assert_gate_on_ms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> $past(us_tick_i));
endmodule

// File: rtl/tsgate_top.sv
module tsgate_top
  import tsg_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned US_PER_MS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic [15:0] stamp_o,
  output logic        gate_o,
  output logic        gate_start_o,
  output logic        gate_end_o
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;

  logic             us_tick;
  res_e             res;
  logic             res_wr;
  logic [DIV_W-1:0] div;

  tsg_us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_pre (
    .clk(clk), .rst_n(rst_n), .us_tick_o(us_tick));

  tsg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .res_o(res),
    .res_wr_o(res_wr), .div_o(div));

  tsg_stamp #(.TS_W(16)) u_stamp (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .res_i(res),
    .res_wr_i(res_wr), .ts_o(stamp_o));

  tsg_gate #(.US_PER_MS(US_PER_MS)) u_gate (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .div_i(div),
    .gate_o(gate_o), .start_o(gate_start_o), .end_o(gate_end_o));
endmodule

// File: tb/test_tsgate_top.sv
`timescale 1ns/1ps
module test_tsgate_top;
  localparam int unsigned CYC   = 4;
  localparam int unsigned MSUS  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata, stamp;
  logic        gate, gstart, gend;
  logic [15:0] f_rdata, f_stamp;
  logic        f_gate, f_gs, f_ge;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tsgate_top #(.CLK_HZ(CYC * 1_000_000), .US_PER_MS(MSUS)) i_tsgate_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stamp_o(stamp),
    .gate_o(gate), .gate_start_o(gstart), .gate_end_o(gend));

  tsgate_top #(.CLK_HZ(1_000_000), .US_PER_MS(MSUS)) i_tsgate_top_fast (
    .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_addr(1'b0),
    .cfg_wdata(16'd0), .cfg_rdata(f_rdata), .stamp_o(f_stamp),
    .gate_o(f_gate), .gate_start_o(f_gs), .gate_end_o(f_ge));

  function automatic int exp_period(input int code);
    case (code)
      0: return CYC;
      1: return CYC * 10;
      2: return CYC * 100;
      default: return CYC * 1000;
    endcase
  endfunction

  function automatic int exp_clamp(input int v);
    if (v == 0) return 1;
    if (v > 16382) return 16382;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    cfg_addr = a;
    #0.1;
    v = int'(cfg_rdata);
    cfg_addr = 1'b0;
  endtask

  task automatic ts_gap(output int n);
    logic [15:0] p;
    p = stamp; n = 0;
    do begin @(negedge clk); n++; end while (stamp == p && n < 20000);
  endtask

  // returns length of the phase that starts at the next gate edge
  task automatic gate_phase(output int n, output int lvl, output int strobe_ok);
    logic g;
    int k;
    g = gate; k = 0;
    do begin @(negedge clk); k++; end while (gate == g && k < 20000);
    lvl = int'(gate);
    strobe_ok = gate ? int'(gstart && !gend) : int'(gend && !gstart);
    g = gate; n = 0;
    do begin
      @(negedge clk); n++;
      if (gate == g && (gstart || gend)) strobe_ok = 0;
    end while (gate == g && n < 20000);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int v, n, lvl, sok, c, d, t0;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 / R3 / R5 reset state
    check("R3 stamp at reset", int'(stamp), 0);
    check("R5 gate low at reset", int'(gate), 0);
    rd(1'b0, v); check("R8 res readback at reset", v, 0);
    rd(1'b1, v); check("R8 div readback at reset", v, 1);

    // R1: first change of stamp at default 1 us res
    t0 = 0;
    while (stamp == 16'd0 && t0 < 100) begin @(negedge clk); t0++; end
    check("R1 first base tick edges", t0, CYC + 1);
    ts_gap(n); check("R1 steady 1us period", n, CYC);

    // R5/R6 first gate high after 1 ms
    gate_phase(n, lvl, sok);
    check("R5 first phase high", lvl, 1);
    check("R6 start strobe single", sok, 1);
    check("R5 high width div=1", n, MSUS * CYC);

    // R7 clamp directed
    wr(1'b1, 16'd0);      rd(1'b1, v); check("R7 zero clamps to 1", v, 1);
    wr(1'b1, 16'd16383);  rd(1'b1, v); check("R7 16383 clamps", v, 16382);
    wr(1'b1, 16'hFFFF);   rd(1'b1, v); check("R7 FFFF clamps", v, 16382);
    wr(1'b1, 16'd16382);  rd(1'b1, v); check("R7 max kept", v, 16382);
    wr(1'b1, 16'd2);      rd(1'b1, v); check("R7 legal kept", v, 2);

    // R8 address 0 with upper garbage
    wr(1'b0, 16'hABC2); rd(1'b0, v); check("R8 res code only bits 1:0", v, 2);

    // R4 switch to 1000 us then back to 1 us
    ts_gap(n);
    wr(1'b0, 16'd3);
    ts_gap(n);
    check_rng("R4 first 1000us increment", n, 1000 * CYC, 1001 * CYC + 1);
    ts_gap(n); check("R2 steady 1000us period", n, exp_period(3));
    wr(1'b0, 16'd0);
    ts_gap(n);
    check_rng("R4 first 1us increment after 1000us", n, CYC, 2 * CYC + 1);
    ts_gap(n); check("R2 steady 1us after switch", n, exp_period(0));

    // R5/R6 gate with div=2 (written above)
    gate_phase(n, lvl, sok);
    gate_phase(n, lvl, sok);
    check("R5 phase width div=2", n, 2 * MSUS * CYC);
    check("R6 strobe at edge", sok, 1);
    gate_phase(n, lvl, sok);
    check("R5 other phase width div=2", n, 2 * MSUS * CYC);
    check("R6 strobe at other edge", sok, 1);

    // constrained random: resolution codes and divisors
    for (int i = 0; i < 6; i++) begin
      c = int'($urandom % 4);
      d = int'($urandom % 5);
      wr(1'b0, 16'(c));
      wr(1'b1, 16'(d));
      rd(1'b1, v); check("R7 random clamp", v, exp_clamp(d));
      ts_gap(n);
      ts_gap(n); check("R2 random period", n, exp_period(c));
      gate_phase(n, lvl, sok);
      gate_phase(n, lvl, sok);
      check("R5 random gate width", n, exp_clamp(d) * MSUS * CYC);
      check("R6 random strobe", sok, 1);
    end

    // R3 wrap on the 1-cycle-per-us instance: runs from reset at 1 us
    begin
      int bad, wraps;
      logic [15:0] p;
      bad = 0; wraps = 0;
      p = f_stamp;
      repeat (66000) begin
        @(negedge clk);
        if (f_stamp != p + 16'd1) bad++;
        if (p == 16'hFFFF && f_stamp == 16'h0000) wraps++;
        p = f_stamp;
      end
      check("R3 stamp steps by one every cycle", bad, 0);
      check_rng("R3 wrap FFFF to 0 seen", wraps, 1, 2);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule